// File: doc/BRIEF.md
# Sequential Floating-Point Mantissa Divider

This block divides one unpacked floating-point value by another. Each operand comes in already split into fields: a sign bit, a class code, a signed exponent and a mantissa. The mantissa holds a leading integer one, `FRAC_W` fraction bits and two extra low bits (guard and round). The result comes back in the same unpacked form, with a sticky bit and two exception flags, so a separate rounding and packing stage can finish the job.

Operand pairs that involve a zero, an infinity or a NaN are settled in one clock. Two normal operands go through a restoring division that produces one quotient bit per clock. The first trial subtraction decides whether the quotient needs its one-bit normalizing shift, so the mantissa always comes out with its top bit set. A one-cycle `start` pulse launches an operation. `busy` covers a running division, and `done` pulses once when the result is ready.

Top module: `fpdiv_seq`

## Requirements
- R1: Class codes are 0 zero, 1 normal, 2 infinity, 3 quiet NaN, 4 signalling NaN. If either operand is a NaN, the result is a copy of a NaN operand (sign, class, sign-extended exponent, mantissa) with both flags low. The chosen operand is the signalling one when exactly one operand is signalling. Otherwise it is the only NaN, or the divisor when both are NaN.
- R2: Infinity over infinity and zero over zero return a fresh quiet NaN (sign 0, exponent 0, mantissa all ones) and raise `flagInvalid`.
- R3: Infinity over a finite value or over zero gives infinity. Zero over a finite value or over infinity gives zero, and so does a normal value over infinity. Exponent, mantissa and sticky of these results are 0, and no flag is raised.
- R4: A normal dividend over zero gives infinity and raises `flagDivZero`.
- R5: Every result that is not a NaN carries the XOR of the operand signs.
- R6: A special-case operation raises `done` in the clock after the edge that accepts `start`, and `busy` stays low.
- R7: For two normal operands the result class is normal, and the mantissa's top bit is 1. The exponent (EXP_W+1 bits, signed) is ea−eb when the dividend mantissa is not smaller than the divisor mantissa, and ea−eb−1 otherwise.
- R8: The quotient mantissa is floor(ma·2^(MANT_W−1)/mb) when ma ≥ mb, and floor(ma·2^MANT_W/mb) when ma < mb, where MANT_W = FRAC_W+3.
- R9: `qSticky` is 1 exactly when the division remainder (the same expression with mod instead of floor) is nonzero.
- R10: A normal division shows `done` MANT_W clocks after the accepting edge when ma ≥ mb, and MANT_W+1 clocks after it when ma < mb. `busy` is high in every clock between those two points.
- R11: A `start` that arrives while `busy` is high has no effect on the running result or its timing.
- R12: `done` lasts one clock. The result outputs hold their values until the next accepted `start`. Both flags are low for a normal division.
- R13: After reset, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, taken when not busy |
| aSign | input | 1 | Dividend sign |
| aCls | input | 3 | Dividend class code |
| aExp | input | EXP_W | Dividend exponent, two's complement |
| aMant | input | FRAC_W+3 | Dividend mantissa |
| bSign | input | 1 | Divisor sign |
| bCls | input | 3 | Divisor class code |
| bExp | input | EXP_W | Divisor exponent, two's complement |
| bMant | input | FRAC_W+3 | Divisor mantissa |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-clock result-ready pulse |
| qSign | output | 1 | Result sign |
| qCls | output | 3 | Result class code |
| qExp | output | EXP_W+1 | Result exponent, two's complement |
| qMant | output | FRAC_W+3 | Result mantissa |
| qSticky | output | 1 | Nonzero remainder indicator |
| flagInvalid | output | 1 | Invalid-operation flag |
| flagDivZero | output | 1 | Divide-by-zero flag |

## Verification
The bench aims at mantissa pairs near the normalization boundary: equal mantissas, one ulp apart in each direction, and the extreme ratios. A design that picked the exponent or the shift the wrong way would return a mantissa with its top bit clear or an exponent off by one, and it would also miss the one-cycle difference in latency. Exact quotients such as 1.5/1.5 and 1.5/1.0 guard the sticky bit, which a design reading the wrong remainder would set. The NaN pairings cover every combination of signalling and quiet, so a wrong choice of operand shows up in the class or mantissa. A `start` injected halfway through a division, carrying a special-case pair, would corrupt the result or end the division early if the handshake did not block it.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NORM = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } fpClass_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeSpecial;  // load a special-case result
    logic takeNormal;   // capture operands, do the first trial subtraction
    logic iterate;      // produce one more quotient bit
  } ctlStrobes_t;

endpackage

// File: rtl/fpdiv_ctrl.sv
module fpdiv_ctrl
  import fpdiv_pkg::*;
#(
  parameter int MANT_W = 11
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        isSpecial,
  input  logic        firstNonNeg,
  output ctlStrobes_t strobes,
  output logic        busy,
  output logic        done
);

  localparam int CNT_W = $clog2(MANT_W + 1);

  typedef enum logic {ST_IDLE, ST_RUN} ctlState_e;

  ctlState_e  state;
  logic [CNT_W-1:0] bitsLeft;
  logic       accept;

  assign accept              = start && (state == ST_IDLE);
  assign strobes.takeSpecial = accept && isSpecial;
  assign strobes.takeNormal  = accept && !isSpecial;
  assign strobes.iterate     = (state == ST_RUN);
  assign busy                = (state == ST_RUN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitsLeft <= '0;
      done     <= 1'b0;
    end else begin
      done <= strobes.takeSpecial || (strobes.iterate && bitsLeft == CNT_W'(1));
      if (strobes.takeNormal) begin
        state    <= ST_RUN;
        // top bit already settled by the first subtraction when nonnegative
        bitsLeft <= firstNonNeg ? CNT_W'(MANT_W - 1) : CNT_W'(MANT_W);
      end else if (strobes.iterate) begin
        bitsLeft <= bitsLeft - CNT_W'(1);
        if (bitsLeft == CNT_W'(1)) state <= ST_IDLE;
      end
    end
  end

  // R10: a running division only ends by presenting its result
  assert_busy_ends_in_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));

  // R10: never running with an exhausted bit budget
  assert_budget_live_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitsLeft != '0));

  // R11: start while running does not restart the bit budget
  assert_start_blocked_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && bitsLeft > CNT_W'(1)) |=> (busy && bitsLeft == $past(bitsLeft) - CNT_W'(1)));

endmodule

// File: rtl/fpdiv_datapath.sv
module fpdiv_datapath
  import fpdiv_pkg::*;
#(
  parameter int FRAC_W = 8,
  parameter int EXP_W  = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrobes_t            strobes,
  input  logic                   aSign,
  input  logic [2:0]             aCls,
  input  logic [EXP_W-1:0]       aExp,
  input  logic [FRAC_W+2:0]      aMant,
  input  logic                   bSign,
  input  logic [2:0]             bCls,
  input  logic [EXP_W-1:0]       bExp,
  input  logic [FRAC_W+2:0]      bMant,
  output logic                   isSpecial,
  output logic                   firstNonNeg,
  output logic                   qSign,
  output logic [2:0]             qCls,
  output logic [EXP_W:0]         qExp,
  output logic [FRAC_W+2:0]      qMant,
  output logic                   qSticky,
  output logic                   flagInvalid,
  output logic                   flagDivZero
);

  localparam int MANT_W = FRAC_W + 3;
  localparam int REM_W  = MANT_W + 1;
  localparam int DIF_W  = MANT_W + 2;

  logic aNan, bNan, aSnan, bSnan, aInf, bInf, aZero, bZero, pickA, xorSign;
  logic             spSign, spInv, spDz;
  logic [2:0]       spCls;
  logic [EXP_W:0]   spExp, expDiff;
  logic [MANT_W-1:0] spMant;
  logic [DIF_W-1:0] initDiff, shifted, stepDiff;
  logic             stepNonNeg;

  logic [REM_W-1:0]  rem;
  logic [MANT_W-1:0] divisor;

  assign aSnan   = (aCls == CLS_SNAN);
  assign bSnan   = (bCls == CLS_SNAN);
  assign aNan    = aSnan || (aCls == CLS_QNAN);
  assign bNan    = bSnan || (bCls == CLS_QNAN);
  assign aInf    = (aCls == CLS_INF);
  assign bInf    = (bCls == CLS_INF);
  assign aZero   = (aCls == CLS_ZERO);
  assign bZero   = (bCls == CLS_ZERO);
  assign xorSign = aSign ^ bSign;
  assign pickA   = aNan && (!bNan || (aSnan && !bSnan));
  assign isSpecial = !((aCls == CLS_NORM) && (bCls == CLS_NORM));

  // Special-case resolution
  always_comb begin
    spSign = 1'b0;
    spCls  = CLS_ZERO;
    spExp  = '0;
    spMant = '0;
    spInv  = 1'b0;
    spDz   = 1'b0;
    if (aNan || bNan) begin
      spSign = pickA ? aSign : bSign;
      spCls  = pickA ? aCls  : bCls;
      spExp  = pickA ? {aExp[EXP_W-1], aExp} : {bExp[EXP_W-1], bExp};
      spMant = pickA ? aMant : bMant;
    end else if ((aInf && bInf) || (aZero && bZero)) begin
      spCls  = CLS_QNAN;
      spMant = '1;
      spInv  = 1'b1;
    end else if (aInf) begin
      spSign = xorSign;
      spCls  = CLS_INF;
    end else if (aZero || bInf) begin
      spSign = xorSign;
      spCls  = CLS_ZERO;
    end else if (bZero) begin
      spSign = xorSign;
      spCls  = CLS_INF;
      spDz   = 1'b1;
    end
  end

  // First trial subtraction straight from the operand ports
  assign initDiff    = {2'b00, aMant} - {2'b00, bMant};
  assign firstNonNeg = !initDiff[DIF_W-1];
  assign expDiff     = {aExp[EXP_W-1], aExp} - {bExp[EXP_W-1], bExp}
                       - {{EXP_W{1'b0}}, !firstNonNeg};

  // One restoring step from the held remainder
  assign shifted    = {rem, 1'b0};
  assign stepDiff   = shifted - {2'b00, divisor};
  assign stepNonNeg = !stepDiff[DIF_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rem         <= '0;
      divisor     <= '0;
      qSign       <= 1'b0;
      qCls        <= CLS_ZERO;
      qExp        <= '0;
      qMant       <= '0;
      flagInvalid <= 1'b0;
      flagDivZero <= 1'b0;
    end else if (strobes.takeSpecial) begin
      rem         <= '0;
      qSign       <= spSign;
      qCls        <= spCls;
      qExp        <= spExp;
      qMant       <= spMant;
      flagInvalid <= spInv;
      flagDivZero <= spDz;
    end else if (strobes.takeNormal) begin
      divisor     <= bMant;
      rem         <= firstNonNeg ? initDiff[REM_W-1:0] : {1'b0, aMant};
      qSign       <= xorSign;
      qCls        <= CLS_NORM;
      qExp        <= expDiff;
      qMant       <= {{(MANT_W-1){1'b0}}, firstNonNeg};
      flagInvalid <= 1'b0;
      flagDivZero <= 1'b0;
    end else if (strobes.iterate) begin
      rem   <= stepNonNeg ? stepDiff[REM_W-1:0] : shifted[REM_W-1:0];
      qMant <= {qMant[MANT_W-2:0], stepNonNeg};
    end
  end

  assign qSticky = |rem;

  // R9: restoring invariant, the remainder stays below the divisor
  assert_rem_below_divisor_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.takeNormal || strobes.iterate) |=> (rem < {1'b0, divisor}));

endmodule

// File: rtl/fpdiv_seq.sv
module fpdiv_seq
  import fpdiv_pkg::*;
#(
  parameter int FRAC_W = 8,
  parameter int EXP_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              aSign,
  input  logic [2:0]        aCls,
  input  logic [EXP_W-1:0]  aExp,
  input  logic [FRAC_W+2:0] aMant,
  input  logic              bSign,
  input  logic [2:0]        bCls,
  input  logic [EXP_W-1:0]  bExp,
  input  logic [FRAC_W+2:0] bMant,
  output logic              busy,
  output logic              done,
  output logic              qSign,
  output logic [2:0]        qCls,
  output logic [EXP_W:0]    qExp,
  output logic [FRAC_W+2:0] qMant,
  output logic              qSticky,
  output logic              flagInvalid,
  output logic              flagDivZero
);

  localparam int MANT_W = FRAC_W + 3;

  ctlStrobes_t strobes;
  logic        isSpecial;
  logic        firstNonNeg;

  fpdiv_ctrl #(.MANT_W(MANT_W)) ctrl (
    .clk(clk), .rstN(rstN), .start(start), .isSpecial(isSpecial),
    .firstNonNeg(firstNonNeg), .strobes(strobes), .busy(busy), .done(done)
  );

  fpdiv_datapath #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .aSign(aSign), .aCls(aCls), .aExp(aExp), .aMant(aMant),
    .bSign(bSign), .bCls(bCls), .bExp(bExp), .bMant(bMant),
    .isSpecial(isSpecial), .firstNonNeg(firstNonNeg),
    .qSign(qSign), .qCls(qCls), .qExp(qExp), .qMant(qMant), .qSticky(qSticky),
    .flagInvalid(flagInvalid), .flagDivZero(flagDivZero)
  );

  // R7: a finished normal quotient is normalized
  assert_norm_msb_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && qCls == CLS_NORM) |-> qMant[MANT_W-1]);

  // R2: invalid only accompanies a generated NaN
  assert_invalid_is_nan_R2: assert property (@(posedge clk) disable iff (!rstN)
    flagInvalid |-> (qCls == CLS_QNAN));

  // R4: divide-by-zero only accompanies an infinity
  assert_dz_is_inf_R4: assert property (@(posedge clk) disable iff (!rstN)
    flagDivZero |-> (qCls == CLS_INF));

  // R6: special pairs finish in one clock without going busy
  assert_special_fast_R6: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !(aCls == CLS_NORM && bCls == CLS_NORM)) |=> (done && !busy));

  // R12: done and busy never overlap
  assert_done_not_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: tb/tb_fpdiv_seq.sv
`timescale 1ns/1ps
module tb_fpdiv_seq;

  localparam int FRAC_W = 8;
  localparam int EXP_W  = 8;
  localparam int MANT_W = FRAC_W + 3;
  localparam logic [MANT_W-1:0] ONES = '1;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic aSign = 0, bSign = 0;
  logic [2:0] aCls = 0, bCls = 0;
  logic [EXP_W-1:0] aExp = 0, bExp = 0;
  logic [MANT_W-1:0] aMant = 0, bMant = 0;
  logic busy, done, qSign, qSticky, flagInvalid, flagDivZero;
  logic [2:0] qCls;
  logic [EXP_W:0] qExp;
  logic [MANT_W-1:0] qMant;

  int total = 0, fails = 0;

  always #4 clk = ~clk;

  fpdiv_seq #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) dut (.*);

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic setOps(input logic sa, input logic [2:0] ca, input int ea, input int ma,
                        input logic sb, input logic [2:0] cb, input int eb, input int mb);
    aSign = sa; aCls = ca; aExp = EXP_W'(ea); aMant = MANT_W'(ma);
    bSign = sb; bCls = cb; bExp = EXP_W'(eb); bMant = MANT_W'(mb);
  endtask

  // pulse start at the current negedge, return clocks until done is seen
  task automatic launch(output int lat, output logic sawBusy);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1; sawBusy = busy;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
      sawBusy = sawBusy | busy;
    end
  endtask

  task automatic testNormal(input logic sa, input int ea, input int ma,
                            input logic sb, input int eb, input int mb);
    int lat; logic sawBusy; longint num, q, r; int expE, expLat;
    setOps(sa, 3'd1, ea, ma, sb, 3'd1, eb, mb);
    if (ma >= mb) begin num = longint'(ma) << (MANT_W-1); expE = ea - eb; expLat = MANT_W; end
    else begin num = longint'(ma) << MANT_W; expE = ea - eb - 1; expLat = MANT_W + 1; end
    q = num / mb; r = num % mb;
    launch(lat, sawBusy);
    chk("R10", "latency", lat, expLat);
    chk("R10", "busy seen", sawBusy, 1);
    chk("R7", "class", qCls, 1);
    chk("R7", "exponent", longint'($signed(qExp)), expE);
    chk("R8", "mantissa", qMant, q);
    chk("R9", "sticky", qSticky, (r != 0));
    chk("R5", "sign", qSign, sa ^ sb);
    chk("R12", "flags", {flagInvalid, flagDivZero}, 0);
  endtask

  task automatic testSpecial(input string req,
                             input logic sa, input logic [2:0] ca, input int ea, input int ma,
                             input logic sb, input logic [2:0] cb, input int eb, input int mb,
                             input logic eS, input logic [2:0] eC, input int eE, input int eM,
                             input logic eInv, input logic eDz);
    int lat; logic sawBusy;
    setOps(sa, ca, ea, ma, sb, cb, eb, mb);
    launch(lat, sawBusy);
    chk("R6", "latency", lat, 1);
    chk("R6", "busy stays low", sawBusy, 0);
    chk(req, "sign", qSign, eS);
    chk(req, "class", qCls, eC);
    chk(req, "exponent", longint'($signed(qExp)), eE);
    chk(req, "mantissa", qMant, eM);
    chk(req, "sticky", qSticky, 0);
    chk(req, "invalid", flagInvalid, eInv);
    chk(req, "divzero", flagDivZero, eDz);
  endtask

  task automatic testReset();
    chk("R13", "busy after reset", busy, 0);
    chk("R13", "done after reset", done, 0);
  endtask

  task automatic testStartIgnored();
    int lat; logic sawBusy;
    setOps(1'b0, 3'd1, 5, 1536, 1'b1, 3'd1, 2, 1280);  // 1.5 / 1.25
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    setOps(1'b0, 3'd0, 0, 0, 1'b0, 3'd0, 0, 0);        // 0/0 while running
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 5; sawBusy = 1'b0;
    chk("R11", "no early done", done, 0);
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    chk("R11", "latency unchanged", lat, MANT_W);
    chk("R11", "mantissa", qMant, (longint'(1536) << (MANT_W-1)) / 1280);
    chk("R11", "exponent", longint'($signed(qExp)), 3);
    chk("R11", "no invalid", flagInvalid, 0);
    chk("R11", "sign", qSign, 1);
  endtask

  task automatic testHold();
    logic [MANT_W-1:0] m; logic [EXP_W:0] e;
    testNormal(1'b0, 10, 1024, 1'b0, 3, 1536);  // 1.0 / 1.5
    m = qMant; e = qExp;
    @(negedge clk);
    chk("R12", "done is one clock", done, 0);
    repeat (3) @(negedge clk);
    chk("R12", "mantissa held", qMant, m);
    chk("R12", "exponent held", qExp, e);
  endtask

  initial begin
    #(8ns * 150000);
    chk("R10", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();

    // normal divides around the normalization boundary
    testNormal(1'b0, 4, 1024, 1'b0, 1, 1024);   // equal
    testNormal(1'b1, 0, 1536, 1'b0, 0, 1024);   // exact 1.5
    testNormal(1'b0, 7, 1024, 1'b1, 2, 1536);   // below one, inexact
    testNormal(1'b1, -3, 1025, 1'b1, 5, 1024);  // one ulp above
    testNormal(1'b0, 0, 1024, 1'b0, 0, 1025);   // one ulp below
    testNormal(1'b0, -128, 2047, 1'b0, 127, 1024); // largest ratio, exponent range
    testNormal(1'b1, 127, 1024, 1'b0, -128, 2047); // smallest ratio
    testNormal(1'b0, 1, 1536, 1'b0, 1, 1536);   // exact, no sticky

    // NaN propagation
    testSpecial("R1", 1'b1, 3'd3, 9, 1800, 1'b0, 3'd1, 2, 1024, 1'b1, 3'd3, 9, 1800, 0, 0);
    testSpecial("R1", 1'b0, 3'd1, 2, 1024, 1'b1, 3'd4, -5, 1100, 1'b1, 3'd4, -5, 1100, 0, 0);
    testSpecial("R1", 1'b0, 3'd3, 1, 1700, 1'b1, 3'd4, 2, 1200, 1'b1, 3'd4, 2, 1200, 0, 0);
    testSpecial("R1", 1'b1, 3'd4, -2, 1300, 1'b0, 3'd3, 4, 1900, 1'b1, 3'd4, -2, 1300, 0, 0);
    testSpecial("R1", 1'b0, 3'd3, 6, 1400, 1'b1, 3'd3, 7, 1500, 1'b1, 3'd3, 7, 1500, 0, 0);
    testSpecial("R1", 1'b0, 3'd4, 6, 1400, 1'b1, 3'd4, 7, 1500, 1'b1, 3'd4, 7, 1500, 0, 0);
    // invalid
    testSpecial("R2", 1'b1, 3'd2, 0, 0, 1'b0, 3'd2, 0, 0, 1'b0, 3'd3, 0, ONES, 1, 0);
    testSpecial("R2", 1'b0, 3'd0, 0, 0, 1'b1, 3'd0, 0, 0, 1'b0, 3'd3, 0, ONES, 1, 0);
    // infinities and zeros, sign R5
    testSpecial("R3", 1'b1, 3'd2, 0, 0, 1'b0, 3'd1, 3, 1100, 1'b1, 3'd2, 0, 0, 0, 0);
    testSpecial("R3", 1'b0, 3'd2, 0, 0, 1'b1, 3'd0, 0, 0, 1'b1, 3'd2, 0, 0, 0, 0);
    testSpecial("R3", 1'b1, 3'd0, 0, 0, 1'b1, 3'd2, 0, 0, 1'b0, 3'd0, 0, 0, 0, 0);
    testSpecial("R3", 1'b0, 3'd0, 0, 0, 1'b1, 3'd1, 4, 1300, 1'b1, 3'd0, 0, 0, 0, 0);
    testSpecial("R5", 1'b1, 3'd1, 3, 1200, 1'b0, 3'd2, 0, 0, 1'b1, 3'd0, 0, 0, 0, 0);
    // divide by zero
    testSpecial("R4", 1'b1, 3'd1, 3, 1200, 1'b1, 3'd0, 0, 0, 1'b0, 3'd2, 0, 0, 0, 1);

    testStartIgnored();
    testHold();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule